// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit integer core and a data memory that is addressed by word and written through per-byte enables. For every memory instruction the core hands over, it forms the effective byte address. It then turns that address into a word address and a four-bit lane mask, and for writes it moves the store operand into the lanes that the mask selects. For reads it takes the word the memory returns and extracts the addressed byte, halfword or word. It sign-extends or zero-fills that value to a full register.

The core drives `req_i` for one cycle together with the raw instruction word and the two source operands. One clock later the unit presents the memory request. A memory with a one-cycle read latency answers on `mem_rdata_i` in the following cycle, and the aligned load result appears on that cycle with `load_valid_o`. Halfword and word accesses that do not fall on their natural boundary, and unsupported size codes, are reported on flags and issue no memory request.

Top module: `lsu_align`

## Requirements
- R1: The effective address is rs1 plus a sign-extended 12-bit byte offset, with no scaling by access size. For reads (opcode 0x03) the offset is instruction bits 31:20. For writes (opcode 0x23) it is bits 31:25 as offset[11:5] and bits 11:7 as offset[4:0]. `mem_addr_o` carries address bits 31:2 and `mem_we_o` is high for writes, both one cycle after `req_i`.
- R2: A byte access (size code funct3[1:0]=0) drives mask 4'b0001 shifted left by address[1:0]. On a write, the low byte of rs2 is placed in all four lanes.
- R3: An aligned halfword access (size code 1) drives mask 4'b0011 when address[1] is 0 and 4'b1100 when it is 1. On a write, the low halfword of rs2 is placed in both halves.
- R4: An aligned word access (size code 2) drives mask 4'b1111, and a write carries rs2 unchanged.
- R5: A halfword with address[0] set, or a word with address[1:0] nonzero, raises `misalign_o` one cycle after `req_i`. It also forces the mask to zero and issues no request.
- R6: Read funct3 values 3, 6 and 7, and write funct3 values above 2, raise `illegal_o` with no request, a zero mask and `misalign_o` low.
- R7: Signed reads (funct3 0 byte, 1 halfword) fill the upper result bits with the top bit of the extracted field.
- R8: Unsigned reads (funct3 4 byte, 5 halfword) fill the upper result bits with zeros.
- R9: `load_valid_o` pulses for one cycle, exactly one cycle after an issued read request. In that cycle `load_data_o` holds the field taken from `mem_rdata_i` at the lane given by the address. A word read (funct3 2) returns the whole word. Writes never raise `load_valid_o`.
- R10: While `rst_ni` is low, all outputs are zero.
- R11: A cycle with `req_i` low, or with an opcode other than 0x03 or 0x23, produces no request and no flag in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Instruction offered this cycle |
| instr_i | input | 32 | Raw instruction word |
| rs1_i | input | 32 | Base address operand |
| rs2_i | input | 32 | Store data operand |
| mem_rdata_i | input | 32 | Word returned by memory, one cycle after a read request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high |
| mem_addr_o | output | ADDR_W-2 | Word address |
| mem_be_o | output | 4 | Byte-lane mask |
| mem_wdata_o | output | 32 | Lane-steered write data |
| misalign_o | output | 1 | Unaligned halfword or word access |
| illegal_o | output | 1 | Unsupported size code |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Extended load result |

## Verification
The request-side outputs (address, mask, write data, both flags) are due one clock edge after `req_i` is sampled. The load result is due one edge later, after the bench's memory model has answered on the intervening edge. The bench drives each instruction at a falling edge and holds it for one cycle. It checks the request outputs at the next falling edge and the load outputs at the falling edge after that. Only then does it issue the next operation, so no two results overlap. Expected values come from bench functions that rebuild the address, mask, lane data and extension from the operands and from the bench's own copy of memory.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XLEN  = 32;
  localparam int NLANE = XLEN / 8;

  localparam logic [6:0] OPC_LOAD  = 7'h03;
  localparam logic [6:0] OPC_STORE = 7'h23;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_X = 2'd3} acc_size_e;

  typedef struct packed {
    logic      mem;
    logic      store;
    acc_size_e size;
    logic      uns;
    logic      illegal;
  } acc_dec_t;

  function automatic acc_dec_t lsu_decode(input logic [6:0] opc, input logic [2:0] f3);
    acc_dec_t d;
    d = '0;
    d.size = acc_size_e'(f3[1:0]);
    d.uns  = f3[2];
    if (opc == OPC_LOAD) begin
      d.mem     = 1'b1;
      d.illegal = (f3[1:0] == 2'b11) || (f3 == 3'd6);
    end else if (opc == OPC_STORE) begin
      d.mem     = 1'b1;
      d.store   = 1'b1;
      d.illegal = (f3 > 3'd2);
    end
    return d;
  endfunction
endpackage

// File: rtl/lsu_agu.sv
module lsu_agu import lsu_pkg::*; (
  input  logic            is_store_i,
  input  logic [6:0]      imm_hi_i,
  input  logic [4:0]      imm_mid_i,
  input  logic [4:0]      imm_lo_i,
  input  logic [XLEN-1:0] base_i,
  output logic [XLEN-1:0] ea_o
);
  logic [11:0] imm12;

  // store offset is split across the word; load offset is contiguous
  assign imm12 = is_store_i ? {imm_hi_i, imm_lo_i} : {imm_hi_i, imm_mid_i};
  assign ea_o  = base_i + {{(XLEN-12){imm12[11]}}, imm12};
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes import lsu_pkg::*; (
  input  acc_size_e        size_i,
  input  logic [1:0]       off_i,
  input  logic [XLEN-1:0]  data_i,
  output logic [NLANE-1:0] be_o,
  output logic [XLEN-1:0]  data_o
);
  always_comb begin
    unique case (size_i)
      SZ_B:    be_o = 4'b0001 << off_i;
      SZ_H:    be_o = off_i[1] ? 4'b1100 : 4'b0011;
      SZ_W:    be_o = 4'b1111;
      default: be_o = 4'b0000;
    endcase
  end

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_B:    data_o[8*k +: 8] = data_i[7:0];
        SZ_H:    data_o[8*k +: 8] = data_i[8*(k%2) +: 8];
        default: data_o[8*k +: 8] = data_i[8*k +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract import lsu_pkg::*; (
  input  acc_size_e       size_i,
  input  logic            uns_i,
  input  logic [1:0]      off_i,
  input  logic [XLEN-1:0] word_i,
  output logic [XLEN-1:0] data_o
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  logic        fill;

  assign byte_sel = word_i[{off_i, 3'b000} +: 8];
  assign half_sel = off_i[1] ? word_i[31:16] : word_i[15:0];

  always_comb begin
    fill = 1'b0;
    unique case (size_i)
      SZ_B: begin
        fill   = ~uns_i & byte_sel[7];
        data_o = {{(XLEN-8){fill}}, byte_sel};
      end
      SZ_H: begin
        fill   = ~uns_i & half_sel[15];
        data_o = {{(XLEN-16){fill}}, half_sel};
      end
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align import lsu_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [31:0]       instr_i,
  input  logic [31:0]       rs1_i,
  input  logic [31:0]       rs2_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-3:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  output logic              misalign_o,
  output logic              illegal_o,
  output logic              load_valid_o,
  output logic [31:0]       load_data_o
);
  localparam int WA_W = ADDR_W - 2;

  acc_dec_t         dec;
  logic [XLEN-1:0]  ea;
  logic             mis_c, ill_c, acc_c;
  logic [NLANE-1:0] be_c;
  logic [XLEN-1:0]  wdata_c;
  logic             unused_fields;

  assign unused_fields = ^instr_i[19:15];
  assign dec = lsu_decode(instr_i[6:0], instr_i[14:12]);

  lsu_agu i_agu (
    .is_store_i (dec.store),
    .imm_hi_i   (instr_i[31:25]),
    .imm_mid_i  (instr_i[24:20]),
    .imm_lo_i   (instr_i[11:7]),
    .base_i     (rs1_i),
    .ea_o       (ea)
  );

  lsu_store_lanes i_lanes (
    .size_i (dec.size),
    .off_i  (ea[1:0]),
    .data_i (rs2_i),
    .be_o   (be_c),
    .data_o (wdata_c)
  );

  // illegal size code takes priority over alignment
  always_comb begin
    unique case (dec.size)
      SZ_H:    mis_c = ea[0];
      SZ_W:    mis_c = |ea[1:0];
      default: mis_c = 1'b0;
    endcase
    ill_c = req_i & dec.mem & dec.illegal;
    mis_c = req_i & dec.mem & ~dec.illegal & mis_c;
    acc_c = req_i & dec.mem & ~dec.illegal & ~mis_c;
  end

  // request stage
  acc_size_e sz_q;
  logic      uns_q;
  logic [1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
      misalign_o  <= 1'b0;
      illegal_o   <= 1'b0;
      sz_q        <= SZ_B;
      uns_q       <= 1'b0;
      off_q       <= '0;
    end else begin
      mem_req_o   <= acc_c;
      mem_we_o    <= acc_c & dec.store;
      mem_addr_o  <= acc_c ? ea[ADDR_W-1:2] : mem_addr_o;
      mem_be_o    <= acc_c ? be_c : '0;
      mem_wdata_o <= (acc_c & dec.store) ? wdata_c : '0;
      misalign_o  <= mis_c;
      illegal_o   <= ill_c;
      if (acc_c) begin
        sz_q  <= dec.size;
        uns_q <= dec.uns;
        off_q <= ea[1:0];
      end
    end
  end

  // response stage
  logic      lv_q;
  acc_size_e sz2_q;
  logic      uns2_q;
  logic [1:0] off2_q;
  logic [XLEN-1:0] ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lv_q   <= 1'b0;
      sz2_q  <= SZ_B;
      uns2_q <= 1'b0;
      off2_q <= '0;
    end else begin
      lv_q   <= mem_req_o & ~mem_we_o;
      sz2_q  <= sz_q;
      uns2_q <= uns_q;
      off2_q <= off_q;
    end
  end

  lsu_load_extract i_extract (
    .size_i (sz2_q),
    .uns_i  (uns2_q),
    .off_i  (off2_q),
    .word_i (mem_rdata_i),
    .data_o (ext)
  );

  assign load_valid_o = lv_q;
  assign load_data_o  = lv_q ? ext : '0;

  localparam int UNUSED_WA = WA_W;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       mem_req_o,
  input logic       mem_we_o,
  input logic [3:0] mem_be_o,
  input logic       misalign_o,
  input logic       illegal_o,
  input logic       load_valid_o
);
  // R5
  misalign_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (!mem_req_o && mem_be_o == 4'b0000));

  // R6
  illegal_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!misalign_o && !mem_req_o && mem_be_o == 4'b0000));

  // R9
  load_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_o |-> $past(mem_req_o && !mem_we_o));

  // R9
  load_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> load_valid_o);

  // R2
  mask_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                   $countones(mem_be_o) == 4));

  // R3
  half_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(mem_be_o) == 2) |-> (mem_be_o == 4'b0011 || mem_be_o == 4'b1100));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> (!mem_req_o && !misalign_o && !illegal_o));

  // R10
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!mem_req_o && !load_valid_o && mem_be_o == 4'b0000);
    end
  end
endmodule

bind lsu_align lsu_align_chk u_lsu_align_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_be_o     (mem_be_o),
  .misalign_o   (misalign_o),
  .illegal_o    (illegal_o),
  .load_valid_o (load_valid_o)
);

// File: tb/test_lsu_align.sv
module test_lsu_align;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] rs1_i = '0;
  logic [31:0] rs2_i = '0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_req_o, mem_we_o, misalign_o, illegal_o, load_valid_o;
  logic [29:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o, load_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  lsu_align i_lsu_align (
    .clk_i, .rst_ni, .req_i, .instr_i, .rs1_i, .rs2_i, .mem_rdata_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o,
    .misalign_o, .illegal_o, .load_valid_o, .load_data_o
  );

  // memory model: 16 words, one-cycle read
  logic [31:0] mem [16];
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[mem_addr_o[3:0]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
      end else begin
        mem_rdata_i <= mem[mem_addr_o[3:0]];
      end
    end
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_load(input logic [2:0] f3, input logic [1:0] off,
                                           input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[{off, 3'b000} +: 8];
    h = off[1] ? w[31:16] : w[15:0];
    case (f3)
      3'd0:    return {{24{b[7]}}, b};
      3'd1:    return {{16{h[15]}}, h};
      3'd4:    return {24'd0, b};
      3'd5:    return {16'd0, h};
      default: return w;
    endcase
  endfunction

  task automatic run_op(input logic [6:0] opc, input logic [2:0] f3, input logic [31:0] rs1,
                        input logic [31:0] rs2, input logic [11:0] imm);
    logic [31:0] ins, ea, wexp, word;
    logic [4:0]  fa, fb;
    logic [1:0]  sz;
    logic [3:0]  bexp;
    logic        kind, st, legal, mis, acc;
    string       t, mt;
    fa = 5'($urandom);
    fb = 5'($urandom);
    st = (opc == 7'h23);
    kind = (opc == 7'h03) || st;
    legal = st ? (f3 <= 3'd2) : (f3 != 3'd3 && f3 != 3'd6 && f3 != 3'd7);
    ins = st ? {imm[11:5], fb, fa, f3, imm[4:0], opc} : {imm, fa, f3, fb, opc};
    ea = rs1 + {{20{imm[11]}}, imm};
    sz = f3[1:0];
    mis = (sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 2'b00);
    acc = kind && legal && !mis;
    bexp = !acc ? 4'h0 : (sz == 2'd0) ? (4'b0001 << ea[1:0]) :
           (sz == 2'd1) ? (ea[1] ? 4'hC : 4'h3) : 4'hF;
    wexp = (sz == 2'd0) ? {4{rs2[7:0]}} : (sz == 2'd1) ? {2{rs2[15:0]}} : rs2;
    t  = !kind ? "R11" : !legal ? "R6" : mis ? "R5" : "R1";
    mt = !acc ? t : (sz == 2'd0) ? "R2" : (sz == 2'd1) ? "R3" : "R4";

    @(negedge clk_i);
    req_i = 1'b1; instr_i = ins; rs1_i = rs1; rs2_i = rs2;
    @(negedge clk_i);
    req_i = 1'b0; instr_i = $urandom; rs1_i = $urandom; rs2_i = $urandom;
    check(t, mem_req_o, acc);
    check(t, misalign_o, kind && legal && mis);
    check(t, illegal_o, kind && !legal);
    check(mt, mem_be_o, bexp);
    word = mem[ea[5:2]];
    if (acc) begin
      check("R1", mem_addr_o, ea[31:2]);
      check("R1", mem_we_o, st);
      if (st) check(mt, mem_wdata_o, wexp);
    end
    @(negedge clk_i);
    check("R9", load_valid_o, acc && !st);
    if (acc && !st)
      check(f3[2] ? "R8" : (f3 == 3'd2) ? "R9" : "R7", load_data_o, exp_load(f3, ea[1:0], word));
    check("R11", mem_req_o, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk_i);
    // R10: outputs idle in reset
    check("R10", mem_req_o, 1'b0);
    check("R10", mem_be_o, 4'h0);
    check("R10", load_valid_o, 1'b0);
    check("R10", {misalign_o, illegal_o, mem_we_o}, 3'b000);
    rst_ni = 1'b1;

    // preload every word with aligned word writes (R4)
    for (int i = 0; i < 16; i++)
      run_op(7'h23, 3'd2, {26'($urandom), 4'(i), 2'b00}, $urandom, 12'd0);

    // directed corners
    run_op(7'h23, 3'd0, 32'h0000_0010, 32'h0000_0080, 12'hFFF);   // R2 byte at lane 3, negative offset
    run_op(7'h03, 3'd0, 32'h0000_000F, 32'h0, 12'd0);             // R7 sign fill from 0x80
    run_op(7'h03, 3'd4, 32'h0000_000F, 32'h0, 12'd0);             // R8 zero fill
    run_op(7'h23, 3'd1, 32'h0000_0020, 32'h0000_FFFF, 12'd2);     // R3 upper half
    run_op(7'h03, 3'd1, 32'h0000_0022, 32'h0, 12'd0);             // R7 halfword 0xFFFF
    run_op(7'h03, 3'd5, 32'h0000_0022, 32'h0, 12'd0);             // R8 halfword zero fill
    run_op(7'h23, 3'd1, 32'h0000_0021, 32'h1234, 12'd0);          // R5 odd halfword
    run_op(7'h03, 3'd2, 32'h0000_0032, 32'h0, 12'd0);             // R5 word at offset 2
    run_op(7'h03, 3'd3, 32'h0000_0030, 32'h0, 12'd0);             // R6 load code 3
    run_op(7'h03, 3'd7, 32'h0000_0031, 32'h0, 12'd0);             // R6 load code 7 beats misalign
    run_op(7'h23, 3'd4, 32'h0000_0030, 32'h0, 12'd0);             // R6 store code 4
    run_op(7'h13, 3'd0, 32'h0000_0030, 32'h0, 12'd0);             // R11 non-memory opcode
    run_op(7'h23, 3'd0, 32'h0000_0100, 32'hA5, 12'h7FF);          // R1 max positive offset
    run_op(7'h03, 3'd0, 32'h0000_0100, 32'h0, 12'h7FF);           // R1 read back

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [6:0] opc;
      logic [2:0] f3;
      int sel;
      sel = $urandom_range(0, 9);
      opc = (sel < 5) ? 7'h03 : (sel < 9) ? 7'h23 : 7'h13;
      f3 = ($urandom_range(0, 3) == 0) ? 3'($urandom) :
           (opc == 7'h23) ? 3'($urandom_range(0, 2)) : 3'(($urandom_range(0, 1) * 4) + $urandom_range(0, 1));
      if ($urandom_range(0, 4) == 0 && opc == 7'h03) f3 = 3'd2;
      run_op(opc, f3, $urandom, $urandom, 12'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule